// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives a host one register port through which it reaches rows of eight internal tables. Table rows are not mapped into the host address space. The host stages row contents in a small bank of data registers and then writes one command word. That word names the table, the row and the direction, and it sets an execute flag. The engine holds the execute flag high while the access is in flight, carries out the access against its local synchronous row storage, and then drops the flag. A host that polls the command register therefore sees the access finish.

Each table has a fixed row width of one to four 32-bit words, and all tables share the same four staging registers. On a write, the staged words are copied into the selected row. On a read, the row is copied back into the staging registers. Staging registers beyond the row width read as zero after a read.

The command layout is chosen by a parameter. The wide layout puts the execute flag at bit 16 and carries a 12-bit row index. The narrow layout puts the execute flag at bit 9.

Top module: `tia_engine`

## Requirements
- R1: Register map: host address 0 is the command register and addresses 1 to 4 are data words 0 to 3. In the wide layout, bit 16 of the command is execute, bit 15 is the direction (0 read, 1 write), bits 14:12 are the table type and bits 11:0 are the row index.
- R2: The execute bit reads back as 1 for exactly LAT (default 3) cycles after the clock edge that accepts a command, and then reads 0. The other command fields read back the values of the accepted command.
- R3: A write command copies the data registers into the selected row when the access completes.
- R4: A read command loads the selected row into the data registers when the access completes.
- R5: Row widths: type 5 (spanning-tree port state) has 4 words, type 0 has 3 words, type 1 has 2 words and every other type has 1 word. A write stores only the first N words. After a read, data registers N and above hold zero.
- R6: A command written while an access is in progress is ignored: it starts no access and does not change the command readback.
- R7: Writes to the data registers while an access is in progress are ignored. The data registers do not change during an access, except for the load at the completion of a read.
- R8: A command write with the execute bit at 0 starts no access and leaves the command readback unchanged.
- R9: Only the low log2(DEPTH) bits of the row index select the row (DEPTH defaults to 16), so indices 7 and 23 address the same row.
- R10: The tables are independent: the same row index in different table types addresses different storage.
- R11: Reset clears busy, the command register, all data registers and every table row.
- R12: In the narrow layout, bit 9 is execute, bit 8 is the direction, bits 7:5 are the type and bits 4:0 are the index. The command readback uses the same positions, and a command with only bit 16 set starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address (0 command, 1..4 data words) |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Combinational read data of the addressed register |

## Verification
The hardest situation to reach is a second command or a data write that arrives while an access is still in flight. Producing it takes host writes on consecutive clock edges, which a polling host never does. The stimulus therefore issues a write command, follows it on the next two edges with a conflicting command and a data write, and only then lets the access finish. Later reads of both target rows and of the staging registers show which write took effect. Latency is checked by sampling the command readback on each edge after acceptance. A second instance built with the narrow layout covers the bit-9 execute flag.

// File: rtl/tia_pkg.sv
package tia_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned MAX_WORDS = 4;
  localparam int unsigned NUM_TYPES = 8;
  localparam int unsigned ROW_W     = WORD_W * MAX_WORDS;

  typedef enum logic {DIR_READ = 1'b0, DIR_WRITE = 1'b1} dir_e;

  typedef struct packed {
    logic       exec;
    dir_e       dir;
    logic [2:0] ttype;
    logic [11:0] idx;
  } cmd_t;

  // words held by one row of a given table type
  function automatic int unsigned row_words(input int unsigned t);
    case (t)
      5:       return 4;
      0:       return 3;
      1:       return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/tia_cmd_fmt.sv
module tia_cmd_fmt
  import tia_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic [31:0] wdata,
  input  cmd_t        cur,
  input  logic        busy,
  output cmd_t        dec,
  output logic [31:0] rb
);
  generate
    if (NARROW) begin : g_narrow
      always_comb begin
        dec.exec  = wdata[9];
        dec.dir   = dir_e'(wdata[8]);
        dec.ttype = wdata[7:5];
        dec.idx   = 12'(wdata[4:0]);
        rb        = {22'b0, busy, cur.dir, cur.ttype, cur.idx[4:0]};
      end
    end else begin : g_wide
      always_comb begin
        dec.exec  = wdata[16];
        dec.dir   = dir_e'(wdata[15]);
        dec.ttype = wdata[14:12];
        dec.idx   = wdata[11:0];
        rb        = {15'b0, busy, cur.dir, cur.ttype, cur.idx};
      end
    end
  endgenerate
endmodule

// File: rtl/tia_seq.sv
module tia_seq #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/tia_store.sv
module tia_store
  import tia_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [2:0]               ttype,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [ROW_W-1:0]         wrow,
  output logic [ROW_W-1:0]         rrow
);
  logic [NUM_TYPES-1:0][ROW_W-1:0] rd_rows;

  generate
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tbl
      localparam int unsigned NW = row_words(t);
      logic [NW*WORD_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
        end else if (we && (ttype == 3'(t))) begin
          mem[idx] <= wrow[NW*WORD_W-1:0];
        end
      end

      assign rd_rows[t] = ROW_W'(mem[idx]);
    end
  endgenerate

  assign rrow = rd_rows[ttype];
endmodule

// File: rtl/tia_engine.sv
module tia_engine
  import tia_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LAT    = 3,
  parameter bit          NARROW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int unsigned IW = $clog2(DEPTH);

  cmd_t                              cmd_q, dec;
  logic [MAX_WORDS-1:0][WORD_W-1:0]  dreg;
  logic [ROW_W-1:0]                  rrow;
  logic [31:0]                       rb;
  logic                              busy, done, start;
  logic                              cmd_wr, is_write, is_read;

  assign cmd_wr   = host_wr && (host_addr == 3'd0);
  assign start    = cmd_wr && dec.exec && !busy;
  assign is_write = done && (cmd_q.dir == DIR_WRITE);
  assign is_read  = done && (cmd_q.dir == DIR_READ);

  tia_cmd_fmt #(.NARROW(NARROW)) u_fmt (
    .wdata(host_wdata), .cur(cmd_q), .busy(busy), .dec(dec), .rb(rb));

  tia_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done));

  tia_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(is_write), .ttype(cmd_q.ttype),
    .idx(cmd_q.idx[IW-1:0]), .wrow(dreg), .rrow(rrow));

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (start) cmd_q <= dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg <= '0;
    end else if (is_read) begin
      dreg <= rrow;
    end else if (host_wr && !busy) begin
      for (int k = 0; k < MAX_WORDS; k++)
        if (host_addr == 3'(k + 1)) dreg[k] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == 3'd0) host_rdata = rb;
    for (int k = 0; k < MAX_WORDS; k++)
      if (host_addr == 3'(k + 1)) host_rdata = dreg[k];
  end

  assert_cmd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(cmd_q));
  assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(dreg));
  assert_noexec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !dec.exec && !busy) |=> !busy);

  generate
    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_chk
      assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && (k >= row_words(32'(cmd_q.ttype)))) |=> (dreg[k] == '0));
    end
  endgenerate
endmodule

// File: tb/tia_engine_test.sv
module tia_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        h_wr = 1'b0, n_wr = 1'b0;
  logic [2:0]  h_addr = '0, n_addr = '0;
  logic [31:0] h_wdata = '0, n_wdata = '0;
  logic [31:0] h_rdata, n_rdata;

  int tests = 0, fails = 0;
  logic [31:0] q_exp[$];
  bit          q_sel[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  tia_engine uut (.clk(clk), .rst_n(rst_n), .host_wr(h_wr), .host_addr(h_addr),
                  .host_wdata(h_wdata), .host_rdata(h_rdata));
  tia_engine #(.NARROW(1'b1)) uut_nb (.clk(clk), .rst_n(rst_n), .host_wr(n_wr),
                  .host_addr(n_addr), .host_wdata(n_wdata), .host_rdata(n_rdata));

  function automatic logic [31:0] wcmd(bit ex, bit dir, int t, int idx);
    return (32'(ex) << 16) | (32'(dir) << 15) | (32'(t) << 12) | 32'(idx);
  endfunction

  task automatic wr(bit sel, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    if (sel) begin n_wr = 1; n_addr = a; n_wdata = d; end
    else     begin h_wr = 1; h_addr = a; h_wdata = d; end
    @(posedge clk); #1;
    h_wr = 0; n_wr = 0;
  endtask

  task automatic run_cmd(bit sel, logic [31:0] c);
    wr(sel, 3'd0, c);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard: push expectation, monitor compares after next edge
  task automatic peek(bit sel, logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    if (sel) n_addr = a; else h_addr = a;
    q_exp.push_back(exp); q_sel.push_back(sel); q_tag.push_back(tag);
    @(posedge clk);
  endtask

  task automatic load4(bit sel, logic [31:0] a, b, c, d);
    wr(sel, 3'd1, a); wr(sel, 3'd2, b); wr(sel, 3'd3, c); wr(sel, 3'd4, d);
  endtask

  task automatic expect4(bit sel, logic [31:0] a, b, c, d, string tag);
    peek(sel, 3'd1, a, tag); peek(sel, 3'd2, b, tag);
    peek(sel, 3'd3, c, tag); peek(sel, 3'd4, d, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (q_exp.size() > 0) begin
      logic [31:0] e, act;
      bit s;
      string t;
      e = q_exp.pop_front(); s = q_sel.pop_front(); t = q_tag.pop_front();
      act = s ? n_rdata : h_rdata;
      tests++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s: actual %08h expected %08h", t, act, e);
      end
    end
  end

  bit finished = 0;
  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [31:0] V0 = 32'h5A5A0001, V1 = 32'h5A5A0002,
                          V2 = 32'h5A5A0003, V3 = 32'h5A5A0004;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R11 reset state
    peek(0, 3'd0, 32'h0, "R11 cmd after reset");
    expect4(0, 0, 0, 0, 0, "R11 data after reset");

    // R1 R2 R3 write spanning-tree row 7, busy for 3 cycles
    load4(0, V0, V1, V2, V3);
    wr(0, 3'd0, wcmd(1, 1, 5, 7));
    peek(0, 3'd0, wcmd(1, 1, 5, 7), "R2 busy cycle 2");
    peek(0, 3'd0, wcmd(1, 1, 5, 7), "R2 busy cycle 3");
    peek(0, 3'd0, wcmd(0, 1, 5, 7), "R2 idle after access R1");

    // R4 read back
    load4(0, 0, 0, 0, 0);
    wr(0, 3'd0, wcmd(1, 0, 5, 7));
    peek(0, 3'd1, 32'h0, "R7 data stable during read");
    peek(0, 3'd1, 32'h0, "R7 data stable during read");
    expect4(0, V0, V1, V2, V3, "R4 R3 row read back");

    // R5 row widths
    load4(0, 32'hA1, 32'hA2, 32'hA3, 32'hA4);
    run_cmd(0, wcmd(1, 1, 1, 7));
    load4(0, 32'hB1, 32'hB2, 32'hB3, 32'hB4);
    run_cmd(0, wcmd(1, 1, 0, 7));
    load4(0, 32'hC1, 32'hC2, 32'hC3, 32'hC4);
    run_cmd(0, wcmd(1, 1, 3, 7));
    run_cmd(0, wcmd(1, 0, 1, 7));
    expect4(0, 32'hA1, 32'hA2, 0, 0, "R5 type1 two words");
    run_cmd(0, wcmd(1, 0, 0, 7));
    expect4(0, 32'hB1, 32'hB2, 32'hB3, 0, "R5 type0 three words");
    run_cmd(0, wcmd(1, 0, 3, 7));
    expect4(0, 32'hC1, 0, 0, 0, "R5 type3 one word");

    // R10 independence, R9 index aliasing
    run_cmd(0, wcmd(1, 0, 5, 7));
    expect4(0, V0, V1, V2, V3, "R10 type5 row untouched");
    load4(0, 0, 0, 0, 0);
    run_cmd(0, wcmd(1, 0, 5, 23));
    expect4(0, V0, V1, V2, V3, "R9 index 23 aliases row 7");

    // R6 R7 command and data writes during busy
    load4(0, 32'h11, 32'h22, 32'h33, 32'h44);
    wr(0, 3'd0, wcmd(1, 1, 5, 2));
    wr(0, 3'd0, wcmd(1, 1, 5, 3));
    wr(0, 3'd1, 32'hBAD);
    @(posedge clk); #1;
    peek(0, 3'd1, 32'h11, "R7 data write during busy ignored");
    peek(0, 3'd0, wcmd(0, 1, 5, 2), "R6 readback keeps first command");
    load4(0, 32'hFF, 32'hFF, 32'hFF, 32'hFF);
    run_cmd(0, wcmd(1, 0, 5, 3));
    expect4(0, 0, 0, 0, 0, "R6 ignored write left row 3 empty");
    run_cmd(0, wcmd(1, 0, 5, 2));
    expect4(0, 32'h11, 32'h22, 32'h33, 32'h44, "R6 R7 row 2 holds staged data");

    // R8 command without execute
    wr(0, 3'd1, 32'h1234);
    wr(0, 3'd0, wcmd(0, 0, 1, 7));
    repeat (4) @(posedge clk);
    peek(0, 3'd0, wcmd(0, 0, 5, 2), "R8 readback unchanged");
    peek(0, 3'd1, 32'h1234, "R8 no read performed");

    // R12 narrow layout
    wr(1, 3'd1, 32'h55);
    wr(1, 3'd0, 32'h3A3);
    peek(1, 3'd0, 32'h3A3, "R12 bit9 busy");
    repeat (2) @(posedge clk); #1;
    wr(1, 3'd1, 32'h0);
    run_cmd(1, 32'h2A3);
    peek(1, 3'd1, 32'h55, "R12 narrow read back");
    wr(1, 3'd1, 32'h0);
    wr(1, 3'd0, 32'h10000 | 32'hA3);
    repeat (4) @(posedge clk);
    peek(1, 3'd0, 32'hA3, "R12 bit16 alone does nothing");
    peek(1, 3'd1, 32'h0, "R12 bit16 alone no load");

    // R11 reset clears table rows
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    load4(0, 32'h9, 32'h9, 32'h9, 32'h9);
    run_cmd(0, wcmd(1, 0, 5, 7));
    expect4(0, 0, 0, 0, 0, "R11 rows cleared by reset");

    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule